// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the device-side transmit engine of a network controller. Software places work in a ring of 16-byte descriptors in host memory and sets up the ring through a small register port: a 64-bit base address split into two words, the ring size in bytes, and the head and tail descriptor indices. While the engine is enabled and head differs from tail, it reads the descriptor at head and streams the referenced buffer bytes onto a byte-wide frame output. If the descriptor asks for it, the engine writes a done flag back into the descriptor. It then moves head forward by one and wraps to zero after the last descriptor.

Host memory is reached through a word-wide request port. The engine holds a request until it is granted and keeps at most one read outstanding. Read data comes back on a separate valid strobe. Frame bytes leave on a valid/ready stream. The stream carries a last flag that closes a frame and a per-byte flag that asks the downstream MAC to append the frame check sequence.

Top module: `tx_ring_engine`

## Requirements
- R1: After reset every register reads 0, tx_valid_o is 0 and mem_req_o is 0.
- R2: The register offsets are control 0x0400 (bit 1 enables the engine), base low 0x3800, base high 0x3804, ring size in bytes 0x3808, head index 0x3810 and tail index 0x3818. Each one reads back the value written.
- R3: No memory request is made and no byte is sent while the engine is disabled or head equals tail. The descriptor at the tail index is never processed.
- R4: The descriptor for index h is read from base + 16*h as four little-endian 32-bit words. Word 0 holds buffer address bits 31:0. Word 1 holds address bits 63:32. Word 2 holds the length in bits 15:0 and the command in bits 31:24. Word 3 holds the status in bits 7:0.
- R5: Exactly length bytes are sent, in address order, starting at the buffer address, whatever its byte alignment. A zero-length descriptor sends nothing.
- R6: tx_last_o is set only on the final byte of a descriptor whose command bit 0 (end of packet) is set. tx_fcs_o equals command bit 1 on every byte of that descriptor.
- R7: When command bit 3 is set, once the data is sent the engine performs one write to word 3 with byte strobe 0001 and bit 0 set. The other bytes of the descriptor are left untouched. When bit 3 is clear, nothing is written.
- R8: Head advances by one per finished descriptor and wraps to 0 after index size/16 - 1.
- R9: A memory request holds its address, direction and data stable until granted. Only one read is outstanding at a time, and no request is made while a read is pending.
- R10: While tx_valid_o is high and tx_ready_i is low, the byte, last and FCS outputs hold.
- R11: Clearing the enable bit lets the descriptor in progress finish, and no further descriptor starts until the bit is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 16 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Byte address, word aligned for reads of data |
| mem_wdata_o | output | 32 | Write data |
| mem_wstrb_o | output | 4 | Write byte strobes |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_ready_i | input | 1 | Downstream accepts byte |
| tx_data_o | output | 8 | Frame byte |
| tx_last_o | output | 1 | Final byte of frame |
| tx_fcs_o | output | 1 | FCS insertion requested for this frame |

## Verification
The assertions take three things for granted. First, the memory side raises mem_rvalid_i only for a granted read and never in the same cycle as the grant. Second, the ring base, size and head registers are written only while the engine is disabled. Third, the tail index is kept below the descriptor count. The bench's memory model follows these rules. It returns read data one or two cycles after a grant chosen by a pseudo-random pattern, and applies writes at the grant. The stimulus sets up every ring register with the enable bit clear, changes only tail and the enable bit while running, and stalls tx_ready_i pseudo-randomly so that hold behaviour is exercised.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam logic [15:0] RA_CTRL    = 16'h0400;
  localparam logic [15:0] RA_BASE_LO = 16'h3800;
  localparam logic [15:0] RA_BASE_HI = 16'h3804;
  localparam logic [15:0] RA_LEN     = 16'h3808;
  localparam logic [15:0] RA_HEAD    = 16'h3810;
  localparam logic [15:0] RA_TAIL    = 16'h3818;

  localparam int CTRL_EN_BIT = 1;
  localparam int CMD_EOP     = 0;
  localparam int CMD_FCS     = 1;
  localparam int CMD_RS      = 3;
  localparam int DESC_SHIFT  = 4;   // 16-byte descriptors

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_BREQ, ST_BWAIT, ST_BOUT, ST_WB, ST_ADV
  } eng_state_e;
endpackage

// File: rtl/tx_ring_regs.sv
module tx_ring_regs
  import tx_ring_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [15:0]       reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              head_adv_i,
  output logic              en_o,
  output logic [63:0]       base_o,
  output logic [IDX_W-1:0]  count_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [IDX_W-1:0]  tail_o
);
  localparam int LEN_W = IDX_W + DESC_SHIFT;

  logic             en_q;
  logic [31:0]      base_lo_q, base_hi_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] head_q, tail_q;
  logic [IDX_W-1:0] head_nxt;

  assign count_o  = len_q[LEN_W-1:DESC_SHIFT];
  assign head_nxt = (head_q == count_o - IDX_W'(1)) ? '0 : head_q + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      len_q     <= '0;
      head_q    <= '0;
      tail_q    <= '0;
    end else begin
      if (head_adv_i) head_q <= head_nxt;
      if (reg_we_i) begin
        case (reg_addr_i)
          RA_CTRL:    en_q      <= reg_wdata_i[CTRL_EN_BIT];
          RA_BASE_LO: base_lo_q <= reg_wdata_i;
          RA_BASE_HI: base_hi_q <= reg_wdata_i;
          RA_LEN:     len_q     <= reg_wdata_i[LEN_W-1:0];
          RA_HEAD:    head_q    <= reg_wdata_i[IDX_W-1:0];
          RA_TAIL:    tail_q    <= reg_wdata_i[IDX_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CTRL:    reg_rdata_o[CTRL_EN_BIT] = en_q;
      RA_BASE_LO: reg_rdata_o = base_lo_q;
      RA_BASE_HI: reg_rdata_o = base_hi_q;
      RA_LEN:     reg_rdata_o = 32'(len_q);
      RA_HEAD:    reg_rdata_o = 32'(head_q);
      RA_TAIL:    reg_rdata_o = 32'(tail_q);
      default: ;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;

  assign en_o   = en_q;
  assign base_o = {base_hi_q, base_lo_q};
  assign head_o = head_q;
  assign tail_o = tail_q;
endmodule

// File: rtl/tx_ring_fetch.sv
module tx_ring_fetch
  import tx_ring_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [63:0]       base_i,
  input  logic [IDX_W-1:0]  count_i,
  input  logic [IDX_W-1:0]  head_i,
  input  logic [IDX_W-1:0]  tail_i,
  output logic              head_adv_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [63:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic [3:0]        mem_wstrb_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              out_busy_i,
  output logic              ld_o,
  output logic [31:0]       ld_word_o,
  output logic [1:0]        ld_lane_o,
  output logic [2:0]        ld_cnt_o,
  output logic              ld_last_o,
  output logic              ld_fcs_o
);
  eng_state_e       state_q;
  logic [63:0]      desc_addr_q;
  logic [1:0]       wi_q;
  logic [3:0][31:0] dw_q;
  logic [63:0]      cur_q;
  logic [15:0]      rem_q;

  logic [2:0] chunk, nb;
  logic       cmd_eop, cmd_fcs, cmd_rs, start;

  assign cmd_eop = dw_q[2][24+CMD_EOP];
  assign cmd_fcs = dw_q[2][24+CMD_FCS];
  assign cmd_rs  = dw_q[2][24+CMD_RS];
  assign chunk   = 3'd4 - {1'b0, cur_q[1:0]};
  assign nb      = (rem_q < {13'd0, chunk}) ? rem_q[2:0] : chunk;
  assign start   = en_i && (count_i != '0) && (head_i != tail_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      desc_addr_q <= '0;
      wi_q        <= '0;
      dw_q        <= '0;
      cur_q       <= '0;
      rem_q       <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          desc_addr_q <= base_i + {{(64-IDX_W-DESC_SHIFT){1'b0}}, head_i, 4'b0000};
          wi_q        <= '0;
          state_q     <= ST_DREQ;
        end
        ST_DREQ: if (mem_gnt_i) state_q <= ST_DWAIT;
        ST_DWAIT: if (mem_rvalid_i) begin
          dw_q[wi_q] <= mem_rdata_i;
          if (wi_q == 2'd3) begin
            cur_q <= {dw_q[1], dw_q[0]};
            rem_q <= dw_q[2][15:0];
            if (dw_q[2][15:0] != '0) state_q <= ST_BREQ;
            else if (cmd_rs)         state_q <= ST_WB;
            else                     state_q <= ST_ADV;
          end else begin
            wi_q    <= wi_q + 2'd1;
            state_q <= ST_DREQ;
          end
        end
        ST_BREQ: if (mem_gnt_i) state_q <= ST_BWAIT;
        ST_BWAIT: if (mem_rvalid_i) begin
          cur_q   <= cur_q + 64'(nb);
          rem_q   <= rem_q - 16'(nb);
          state_q <= ST_BOUT;
        end
        ST_BOUT: if (!out_busy_i) begin
          if (rem_q != '0) state_q <= ST_BREQ;
          else if (cmd_rs) state_q <= ST_WB;
          else             state_q <= ST_ADV;
        end
        ST_WB:  if (mem_gnt_i) state_q <= ST_ADV;
        ST_ADV: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = desc_addr_q + {60'd0, wi_q, 2'b00};
    mem_wdata_o = {dw_q[3][31:1], 1'b1};
    mem_wstrb_o = 4'b0001;
    case (state_q)
      ST_DREQ: mem_req_o = 1'b1;
      ST_BREQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {cur_q[63:2], 2'b00};
      end
      ST_WB: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = desc_addr_q + 64'd12;
      end
      default: ;
    endcase
  end

  assign head_adv_o = (state_q == ST_ADV);
  assign ld_o       = (state_q == ST_BWAIT) && mem_rvalid_i;
  assign ld_word_o  = mem_rdata_i;
  assign ld_lane_o  = cur_q[1:0];
  assign ld_cnt_o   = nb;
  assign ld_last_o  = cmd_eop && (rem_q == {13'd0, nb});
  assign ld_fcs_o   = cmd_fcs;
endmodule

// File: rtl/tx_ring_byteout.sv
module tx_ring_byteout (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ld_i,
  input  logic [31:0] ld_word_i,
  input  logic [1:0]  ld_lane_i,
  input  logic [2:0]  ld_cnt_i,
  input  logic        ld_last_i,
  input  logic        ld_fcs_i,
  output logic        busy_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  output logic        tx_fcs_o
);
  logic [31:0] word_q;
  logic [1:0]  idx_q;
  logic [2:0]  rem_q;
  logic        last_q, fcs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      last_q <= 1'b0;
      fcs_q  <= 1'b0;
    end else if (ld_i) begin
      word_q <= ld_word_i;
      idx_q  <= ld_lane_i;
      rem_q  <= ld_cnt_i;
      last_q <= ld_last_i;
      fcs_q  <= ld_fcs_i;
    end else if (tx_valid_o && tx_ready_i) begin
      idx_q <= idx_q + 2'd1;
      rem_q <= rem_q - 3'd1;
    end
  end

  assign tx_valid_o = (rem_q != '0);
  assign busy_o     = tx_valid_o;
  assign tx_data_o  = word_q[{idx_q, 3'b000} +: 8];
  assign tx_last_o  = last_q && (rem_q == 3'd1);
  assign tx_fcs_o   = fcs_q;
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
  import tx_ring_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [15:0] reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [63:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic [3:0]  mem_wstrb_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  output logic        tx_fcs_o
);
  logic             en_w, head_adv_w, busy_w;
  logic [63:0]      base_w;
  logic [IDX_W-1:0] count_w, head_w, tail_w;
  logic             ld_w, ld_last_w, ld_fcs_w;
  logic [31:0]      ld_word_w;
  logic [1:0]       ld_lane_w;
  logic [2:0]       ld_cnt_w;

  tx_ring_regs #(.IDX_W(IDX_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .head_adv_i(head_adv_w), .en_o(en_w), .base_o(base_w),
    .count_o(count_w), .head_o(head_w), .tail_o(tail_w)
  );

  tx_ring_fetch #(.IDX_W(IDX_W)) u_fetch (
    .clk_i, .rst_ni, .en_i(en_w), .base_i(base_w), .count_i(count_w),
    .head_i(head_w), .tail_i(tail_w), .head_adv_o(head_adv_w),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_wstrb_o,
    .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i, .out_busy_i(busy_w),
    .ld_o(ld_w), .ld_word_o(ld_word_w), .ld_lane_o(ld_lane_w),
    .ld_cnt_o(ld_cnt_w), .ld_last_o(ld_last_w), .ld_fcs_o(ld_fcs_w)
  );

  tx_ring_byteout u_out (
    .clk_i, .rst_ni, .ld_i(ld_w), .ld_word_i(ld_word_w), .ld_lane_i(ld_lane_w),
    .ld_cnt_i(ld_cnt_w), .ld_last_i(ld_last_w), .ld_fcs_i(ld_fcs_w),
    .busy_o(busy_w), .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_last_o, .tx_fcs_o
  );
endmodule

// File: rtl/tx_ring_chk.sv
module tx_ring_chk #(
  parameter int IDX_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [15:0]      reg_addr_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [63:0]      mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic [3:0]       mem_wstrb_o,
  input logic             mem_gnt_i,
  input logic             mem_rvalid_i,
  input logic             tx_valid_o,
  input logic             tx_ready_i,
  input logic [7:0]       tx_data_o,
  input logic             tx_last_o,
  input logic             tx_fcs_o,
  input logic [IDX_W-1:0] head_w,
  input logic [IDX_W-1:0] count_w
);
  logic rd_pend_q;
  logic head_wr;

  assign head_wr = reg_we_i && (reg_addr_i == 16'h3810);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rd_pend_q <= 1'b0;
    else if (mem_req_o && mem_gnt_i && !mem_we_o) rd_pend_q <= 1'b1;
    else if (mem_rvalid_i)                      rd_pend_q <= 1'b0;
  end

  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                               && $stable(mem_wdata_o) && $stable(mem_wstrb_o));

  a_r9_single_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q |-> !mem_req_o);

  a_r10_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)
                                  && $stable(tx_last_o) && $stable(tx_fcs_o));

  a_r7_wb_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_wstrb_o == 4'b0001 && mem_wdata_o[0] && mem_addr_o[3:0] == 4'hC);

  a_r8_head_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_wr ##1 (head_w != $past(head_w)) |->
      head_w == (($past(head_w) == $past(count_w) - IDX_W'(1)) ? '0 : $past(head_w) + IDX_W'(1)));
endmodule

bind tx_ring_engine tx_ring_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .mem_wstrb_o(mem_wstrb_o), .mem_gnt_i(mem_gnt_i),
  .mem_rvalid_i(mem_rvalid_i), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
  .tx_data_o(tx_data_o), .tx_last_o(tx_last_o), .tx_fcs_o(tx_fcs_o),
  .head_w(head_w), .count_w(count_w)
);

// File: tb/sim_tx_ring_engine.sv
module sim_tx_ring_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic [3:0]  mem_wstrb;
  logic        tx_valid, tx_ready = 1'b0, tx_last, tx_fcs;
  logic [7:0]  tx_data;

  localparam logic [63:0] RING = 64'h100;

  int n_checks = 0, n_fail = 0;
  int req_cnt = 0, wb_cnt = 0;
  logic [63:0] first_addr = '0;
  bit seen_first = 0;
  bit done = 0;
  logic [7:0]  mem [0:4095];
  logic [9:0]  exp_q [$];
  logic [15:0] lf = 16'hACE1;
  logic        pend = 1'b0;
  logic        pdly = 1'b0;
  logic [31:0] pword = '0;

  always #5 clk = ~clk;

  tx_ring_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_wstrb_o(mem_wstrb), .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid), .tx_ready_i(tx_ready),
    .tx_data_o(tx_data), .tx_last_o(tx_last), .tx_fcs_o(tx_fcs)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory model: writes at grant, reads return 1 or 2 cycles after grant
  always @(posedge clk) begin
    if (mem_rvalid) mem_rvalid <= 1'b0;
    else if (pend && !pdly) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= pword;
      pend       <= 1'b0;
    end else if (pend) pdly <= 1'b0;
    if (mem_req && mem_gnt) begin
      req_cnt <= req_cnt + 1;
      if (!seen_first) begin
        seen_first <= 1;
        first_addr <= mem_addr;
      end
      if (mem_we) begin
        wb_cnt <= wb_cnt + 1;
        for (int b = 0; b < 4; b++)
          if (mem_wstrb[b]) mem[{mem_addr[11:2], 2'b00} + 12'(b)] <= mem_wdata[8*b +: 8];
      end else begin
        pend  <= 1'b1;
        pdly  <= lf[0];
        pword <= {mem[{mem_addr[11:2], 2'b11}], mem[{mem_addr[11:2], 2'b10}],
                  mem[{mem_addr[11:2], 2'b01}], mem[{mem_addr[11:2], 2'b00}]};
      end
    end
  end

  // negedge: new grant/ready, then scoreboard monitor for the coming edge
  always @(negedge clk) begin
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    mem_gnt  = lf[0] | lf[3];
    tx_ready = lf[2] | lf[5];
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk("R5 unexpected byte", {54'd0, tx_fcs, tx_last, tx_data}, 64'h3ff);
      else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk("R5 R6 byte/last/fcs", {54'd0, tx_fcs, tx_last, tx_data}, {54'd0, e});
      end
    end
  end

  task automatic reg_wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    #1;
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    #1;
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    #1;
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic put_desc(int idx, logic [63:0] baddr, int len, logic [7:0] cmd, logic [7:0] seed);
    logic [11:0] da;
    da = 12'(RING) + 12'(idx * 16);
    for (int k = 0; k < 8; k++) mem[da + 12'(k)] = baddr[8*k +: 8];
    mem[da + 8]  = 8'(len);
    mem[da + 9]  = 8'(len >> 8);
    mem[da + 10] = 8'h00;
    mem[da + 11] = cmd;
    mem[da + 12] = 8'h00;
    mem[da + 13] = 8'h5A;
    mem[da + 14] = 8'hC3;
    mem[da + 15] = 8'h3C;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 7);
      mem[baddr[11:0] + 12'(i)] = b;
      exp_q.push_back({cmd[1], cmd[0] && (i == len - 1), b});
    end
  endtask

  task automatic wait_head(int target);
    logic [31:0] h;
    for (int t = 0; t < 4000; t++) begin
      reg_rd(16'h3810, h);
      if (h == 32'(target)) break;
    end
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    forever begin
      @(posedge clk);
      if (done) break;
    end
  end

  initial begin
    logic [31:0] d;
    int wb0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 tx_valid", {63'd0, tx_valid}, 0);
    chk("R1 mem_req", {63'd0, mem_req}, 0);
    reg_rd(16'h0400, d); chk("R1 ctrl", 64'(d), 0);
    reg_rd(16'h3808, d); chk("R1 size", 64'(d), 0);
    reg_rd(16'h3810, d); chk("R1 head", 64'(d), 0);
    rst_n = 1'b1;
    @(negedge clk);
    reg_rd(16'h3818, d); chk("R1 tail", 64'(d), 0);

    // R2: register map readback
    reg_wr(16'h3800, 32'(RING));
    reg_wr(16'h3804, 32'hABCD_0001);
    reg_rd(16'h3804, d); chk("R2 base hi", 64'(d), 64'hABCD_0001);
    reg_wr(16'h3804, 32'h0);
    reg_rd(16'h3800, d); chk("R2 base lo", 64'(d), 64'(RING));
    reg_wr(16'h3808, 32'd128);
    reg_rd(16'h3808, d); chk("R2 size bytes", 64'(d), 128);

    // R3: enabled but head == tail
    reg_wr(16'h0400, 32'h2);
    reg_rd(16'h0400, d); chk("R2 ctrl enable bit1", 64'(d), 2);
    repeat (40) @(negedge clk);
    chk("R3 no request when head==tail", 64'(req_cnt), 0);
    reg_wr(16'h0400, 32'h0);

    // R3/R7: one descriptor pending while disabled
    put_desc(0, 64'h400, 5, 8'h0B, 8'h11);
    reg_wr(16'h3818, 32'd1);
    repeat (40) @(negedge clk);
    chk("R3 no request when disabled", 64'(req_cnt), 0);
    chk("R3 no bytes when disabled", 64'(exp_q.size()), 5);
    reg_wr(16'h0400, 32'h2);
    wait_head(1);
    repeat (10) @(negedge clk);
    chk("R4 first fetch at base+16*head", first_addr, RING);
    chk("R5 all bytes sent", 64'(exp_q.size()), 0);
    chk("R7 done bit written", 64'(mem[12'h10C]), 1);
    chk("R7 neighbour bytes kept", {48'd0, mem[12'h10D], mem[12'h10E]}, 64'h5AC3);
    chk("R7 one write", 64'(wb_cnt), 1);

    // R5/R6/R7: unaligned, multi-descriptor frame, zero length
    reg_wr(16'h0400, 32'h0);
    wb0 = wb_cnt;
    put_desc(1, 64'h503, 7, 8'h00, 8'h40);
    put_desc(2, 64'h601, 2, 8'h0B, 8'h80);
    put_desc(3, 64'h700, 0, 8'h09, 8'h00);
    reg_wr(16'h3818, 32'd4);
    reg_wr(16'h0400, 32'h2);
    wait_head(4);
    repeat (10) @(negedge clk);
    chk("R5 unaligned and zero-length bytes", 64'(exp_q.size()), 0);
    chk("R7 write count", 64'(wb_cnt - wb0), 2);
    chk("R7 no write without bit3", 64'(mem[12'h11C]), 0);
    chk("R7 zero-length done", 64'(mem[12'h13C]), 1);

    // R8: wrap around the ring end
    reg_wr(16'h0400, 32'h0);
    seen_first = 0;
    for (int k = 0; k < 6; k++) put_desc((4 + k) % 8, 64'h800 + 64'(k * 16), 3, 8'h01, 8'(k * 9));
    reg_wr(16'h3818, 32'd2);
    reg_wr(16'h0400, 32'h2);
    wait_head(2);
    repeat (10) @(negedge clk);
    reg_rd(16'h3810, d); chk("R8 head wrapped", 64'(d), 2);
    chk("R4 fetch at index 4", first_addr, RING + 64'h40);
    chk("R8 wrapped bytes", 64'(exp_q.size()), 0);

    // R11: disable mid-descriptor
    reg_wr(16'h0400, 32'h0);
    put_desc(2, 64'h900, 40, 8'h03, 8'h21);
    put_desc(3, 64'hA00, 40, 8'h03, 8'h77);
    reg_wr(16'h3818, 32'd4);
    reg_wr(16'h0400, 32'h2);
    for (int t = 0; t < 2000 && exp_q.size() == 80; t++) @(negedge clk);
    reg_wr(16'h0400, 32'h0);
    repeat (400) @(negedge clk);
    reg_rd(16'h3810, d); chk("R11 current descriptor finished", 64'(d), 3);
    chk("R11 next not started", 64'(exp_q.size()), 40);
    reg_wr(16'h0400, 32'h2);
    wait_head(4);
    repeat (10) @(negedge clk);
    chk("R11 resumed", 64'(exp_q.size()), 0);
    chk("R10 stream consumed under stalls", 64'(exp_q.size()), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule